// File: doc/BRIEF.md
# Job Slot Command Controller

This block is the register front end of one job slot in a graphics job manager. Software stages the next job in a set of shadow registers: a 64-bit head pointer, a 64-bit core affinity mask and a configuration word. It then arms the slot by writing the start code to the next-command register. On that write the controller moves the staged values into the active registers, clears the staged head pointer and the next-command register, and marks the slot busy. One cycle later it closes the job. It then signals either a job-done or a job-failed pulse to the parent job controller.

A second, immediate command register accepts stop requests. Soft and hard stops are decoded. Two pairs of conditional stops act only when the job-chain flag of the active configuration has the matching value. An accepted stop produces a one-cycle pulse and leaves the status unchanged. A start code written to the immediate register is illegal: it raises a protocol-error pulse and starts nothing. Job execution, memory fetch and interrupt merging belong to other blocks. The exit code of a job comes in from the execution side on `exit_code_i`.

Top module: `slot_cmd_ctrl`

## Requirements
- R1: A write to the immediate command register (offset 0x20) with the code 0 or with any value of 8 or more produces no pulse and changes no register.
- R2: A write to the next-command register (offset 0x54) stores the written value, which reads back unchanged. A start (code 1) happens only when the written value is 1. Any other value moves nothing and leaves the status alone.
- R3: On a start, the status reads ACTIVE (0x08) in the next cycle. In the same cycle the active head (0x00/0x04) and the active tail (0x08/0x0C) both hold the staged head, the active affinity (0x10/0x14) holds the staged affinity and the active config (0x18) holds the staged config.
- R4: After a start, the staged head (0x40/0x44) and the next-command register read 0. The staged affinity (0x48/0x4C) and the staged config (0x50) keep their values.
- R5: One cycle after the start transfer the job closes. If `exit_code_i` lies in 0x40 to 0x7F, the status takes that code and `job_failed_o` pulses for one cycle. Otherwise the status becomes DONE (0x01) and `job_done_o` pulses for one cycle. The two pulses never occur together.
- R6: Immediate codes 2 (soft stop) and 3 (hard stop) always give a one-cycle `stop_accept_o` pulse in the cycle after the write, with the status unchanged. `stop_hard_o` is high with that pulse for codes 3, 5 and 7 and low for codes 2, 4 and 6.
- R7: Codes 4 (soft) and 5 (hard) are accepted only when bit 8 of the active config is 0. Codes 6 (soft) and 7 (hard) are accepted only when that bit is 1. When the condition is not met, there is no pulse.
- R8: Writing code 1 to the immediate command register gives a one-cycle `proto_err_o` pulse in the next cycle and no transfer, no status change and no done or failed pulse.
- R9: Writes have effect only at offsets 0x20, 0x40, 0x44, 0x48, 0x4C, 0x50 and 0x54. Writes to the active registers, to the status register (0x1C) or to any other offset change no readback.
- R10: After reset every register reads 0, the status reads IDLE (0x00) and all pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | AW (8) | Byte offset of the write |
| wr_data | input | DW (32) | Write data |
| rd_addr | input | AW (8) | Byte offset of the read |
| rd_data | output | DW (32) | Read data, combinational by default |
| exit_code_i | input | 8 | Exit code of the running job, sampled when the job closes |
| job_done_o | output | 1 | Pulse: job closed with a no-fault status |
| job_failed_o | output | 1 | Pulse: job closed with a fault status |
| stop_accept_o | output | 1 | Pulse: a stop command was accepted |
| stop_hard_o | output | 1 | Qualifies `stop_accept_o` as a hard stop |
| proto_err_o | output | 1 | Pulse: start code written to the immediate register |

## Verification
The closing of a job and the acceptance of a stop command can land in the same cycle. The close happens one cycle after the start write, and a stop written on the very next bus cycle is decoded at that same edge. The bench provokes this with a start write followed at once by a soft-stop write. The scoreboard merges both expected events into one cycle and requires `job_done_o` and `stop_accept_o` high together, with the status ending at DONE. A protocol error placed right after a start is judged the same way against the done pulse.

// File: rtl/slotc_pkg.sv
package slotc_pkg;
   // register offsets (byte addresses)
   localparam logic [7:0] OFS_ACT_HEAD_LO = 8'h00;
   localparam logic [7:0] OFS_ACT_HEAD_HI = 8'h04;
   localparam logic [7:0] OFS_ACT_TAIL_LO = 8'h08;
   localparam logic [7:0] OFS_ACT_TAIL_HI = 8'h0C;
   localparam logic [7:0] OFS_ACT_AFF_LO  = 8'h10;
   localparam logic [7:0] OFS_ACT_AFF_HI  = 8'h14;
   localparam logic [7:0] OFS_ACT_CFG     = 8'h18;
   localparam logic [7:0] OFS_STATUS      = 8'h1C;
   localparam logic [7:0] OFS_CMD_NOW     = 8'h20;
   localparam logic [7:0] OFS_NXT_HEAD_LO = 8'h40;
   localparam logic [7:0] OFS_NXT_HEAD_HI = 8'h44;
   localparam logic [7:0] OFS_NXT_AFF_LO  = 8'h48;
   localparam logic [7:0] OFS_NXT_AFF_HI  = 8'h4C;
   localparam logic [7:0] OFS_NXT_CFG     = 8'h50;
   localparam logic [7:0] OFS_NXT_CMD     = 8'h54;

   // status codes
   localparam logic [7:0] ST_IDLE   = 8'h00;
   localparam logic [7:0] ST_DONE   = 8'h01;
   localparam logic [7:0] ST_ACTIVE = 8'h08;

   typedef enum logic [2:0] {
      CMD_NOP      = 3'd0,
      CMD_START    = 3'd1,
      CMD_SOFT     = 3'd2,
      CMD_HARD     = 3'd3,
      CMD_SOFT_NC  = 3'd4,
      CMD_HARD_NC  = 3'd5,
      CMD_SOFT_CH  = 3'd6,
      CMD_HARD_CH  = 3'd7
   } slot_cmd_e;

   function automatic logic is_fault(input logic [7:0] code);
      return code[7:6] == 2'b01;
   endfunction
endpackage

// File: rtl/slotc_cmd_dec.sv
module slotc_cmd_dec
   import slotc_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          cmd_wr,
   input  logic [DW-1:0] cmd_val,
   input  logic          chain,
   output logic          stop_ok,
   output logic          stop_hard,
   output logic          start_err
);
   logic in_range;
   assign in_range = (cmd_val[DW-1:3] == '0);

   always_comb begin
      stop_ok   = 1'b0;
      stop_hard = 1'b0;
      start_err = 1'b0;
      if (cmd_wr && in_range) begin
         case (slot_cmd_e'(cmd_val[2:0]))
            CMD_START:   start_err = 1'b1;
            CMD_SOFT:    stop_ok   = 1'b1;
            CMD_HARD:    begin stop_ok = 1'b1;   stop_hard = 1'b1;   end
            CMD_SOFT_NC: stop_ok   = !chain;
            CMD_HARD_NC: begin stop_ok = !chain; stop_hard = !chain; end
            CMD_SOFT_CH: stop_ok   = chain;
            CMD_HARD_CH: begin stop_ok = chain;  stop_hard = chain;  end
            default:     ;
         endcase
      end
   end
endmodule

// File: rtl/slotc_shadow.sv
module slotc_shadow
   import slotc_pkg::*;
#(
   parameter int AW = 8,
   parameter int DW = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [AW-1:0]   wr_addr,
   input  logic [DW-1:0]   wr_data,
   output logic [2*DW-1:0] nxt_head,
   output logic [2*DW-1:0] nxt_aff,
   output logic [DW-1:0]   nxt_cfg,
   output logic [DW-1:0]   nxt_cmd,
   output logic            start_fire
);
   assign start_fire = wr_en && (wr_addr == AW'(OFS_NXT_CMD))
                       && (wr_data == DW'(CMD_START));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nxt_head <= '0;
         nxt_aff  <= '0;
         nxt_cfg  <= '0;
         nxt_cmd  <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            AW'(OFS_NXT_HEAD_LO): nxt_head[DW-1:0]    <= wr_data;
            AW'(OFS_NXT_HEAD_HI): nxt_head[2*DW-1:DW] <= wr_data;
            AW'(OFS_NXT_AFF_LO):  nxt_aff[DW-1:0]     <= wr_data;
            AW'(OFS_NXT_AFF_HI):  nxt_aff[2*DW-1:DW]  <= wr_data;
            AW'(OFS_NXT_CFG):     nxt_cfg             <= wr_data;
            AW'(OFS_NXT_CMD): begin
               // stored, then consumed at once when it is a start
               nxt_cmd <= start_fire ? '0 : wr_data;
               if (start_fire) nxt_head <= '0;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/slotc_active.sv
module slotc_active
   import slotc_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_fire,
   input  logic [2*DW-1:0] nxt_head,
   input  logic [2*DW-1:0] nxt_aff,
   input  logic [DW-1:0]   nxt_cfg,
   input  logic [7:0]      exit_code,
   output logic [2*DW-1:0] act_head,
   output logic [2*DW-1:0] act_tail,
   output logic [2*DW-1:0] act_aff,
   output logic [DW-1:0]   act_cfg,
   output logic [7:0]      status,
   output logic            done_p,
   output logic            fail_p
);
   logic pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_head <= '0;
         act_tail <= '0;
         act_aff  <= '0;
         act_cfg  <= '0;
         status   <= ST_IDLE;
         pending  <= 1'b0;
         done_p   <= 1'b0;
         fail_p   <= 1'b0;
      end else begin
         done_p <= 1'b0;
         fail_p <= 1'b0;
         if (pending) begin
            pending <= 1'b0;
            if (is_fault(exit_code)) begin
               status <= exit_code;
               fail_p <= 1'b1;
            end else begin
               status <= ST_DONE;
               done_p <= 1'b1;
            end
         end
         if (start_fire) begin
            status   <= ST_ACTIVE;
            act_head <= nxt_head;
            act_tail <= nxt_head;
            act_aff  <= nxt_aff;
            act_cfg  <= nxt_cfg;
            pending  <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/slot_cmd_ctrl.sv
module slot_cmd_ctrl
   import slotc_pkg::*;
#(
   parameter int AW        = 8,
   parameter int DW        = 32,
   parameter int CHAIN_BIT = 8,
   parameter bit RD_REG    = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   input  logic [7:0]    exit_code_i,
   output logic          job_done_o,
   output logic          job_failed_o,
   output logic          stop_accept_o,
   output logic          stop_hard_o,
   output logic          proto_err_o
);
   localparam int QW = 2 * DW;

   if (DW != 32) begin : g_bad_dw
      $error("slot_cmd_ctrl: DW must be 32");
   end
   if (AW < 7) begin : g_bad_aw
      $error("slot_cmd_ctrl: AW too small for the register map");
   end
   if (CHAIN_BIT >= DW) begin : g_bad_chain
      $error("slot_cmd_ctrl: CHAIN_BIT outside config word");
   end

   logic [QW-1:0] nxt_head_w, nxt_aff_w, act_head_w, act_tail_w, act_aff_w;
   logic [DW-1:0] nxt_cfg_w, nxt_cmd_w, act_cfg_w;
   logic [7:0]    status_w;
   logic          start_fire, stop_ok, stop_hard, start_err, cmd_wr;
   logic [DW-1:0] rd_mux;

   assign cmd_wr = wr_en && (wr_addr == AW'(OFS_CMD_NOW));

   slotc_shadow #(.AW(AW), .DW(DW)) u_shadow (
      .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
      .nxt_head(nxt_head_w), .nxt_aff(nxt_aff_w), .nxt_cfg(nxt_cfg_w),
      .nxt_cmd(nxt_cmd_w), .start_fire(start_fire)
   );

   slotc_active #(.DW(DW)) u_active (
      .clk, .rst_n, .start_fire,
      .nxt_head(nxt_head_w), .nxt_aff(nxt_aff_w), .nxt_cfg(nxt_cfg_w),
      .exit_code(exit_code_i),
      .act_head(act_head_w), .act_tail(act_tail_w), .act_aff(act_aff_w),
      .act_cfg(act_cfg_w), .status(status_w),
      .done_p(job_done_o), .fail_p(job_failed_o)
   );

   slotc_cmd_dec #(.DW(DW)) u_dec (
      .cmd_wr, .cmd_val(wr_data), .chain(act_cfg_w[CHAIN_BIT]),
      .stop_ok, .stop_hard, .start_err
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stop_accept_o <= 1'b0;
         stop_hard_o   <= 1'b0;
         proto_err_o   <= 1'b0;
      end else begin
         stop_accept_o <= stop_ok;
         stop_hard_o   <= stop_ok && stop_hard;
         proto_err_o   <= start_err;
      end
   end

   always_comb begin
      case (rd_addr)
         AW'(OFS_ACT_HEAD_LO): rd_mux = act_head_w[DW-1:0];
         AW'(OFS_ACT_HEAD_HI): rd_mux = act_head_w[QW-1:DW];
         AW'(OFS_ACT_TAIL_LO): rd_mux = act_tail_w[DW-1:0];
         AW'(OFS_ACT_TAIL_HI): rd_mux = act_tail_w[QW-1:DW];
         AW'(OFS_ACT_AFF_LO):  rd_mux = act_aff_w[DW-1:0];
         AW'(OFS_ACT_AFF_HI):  rd_mux = act_aff_w[QW-1:DW];
         AW'(OFS_ACT_CFG):     rd_mux = act_cfg_w;
         AW'(OFS_STATUS):      rd_mux = DW'(status_w);
         AW'(OFS_NXT_HEAD_LO): rd_mux = nxt_head_w[DW-1:0];
         AW'(OFS_NXT_HEAD_HI): rd_mux = nxt_head_w[QW-1:DW];
         AW'(OFS_NXT_AFF_LO):  rd_mux = nxt_aff_w[DW-1:0];
         AW'(OFS_NXT_AFF_HI):  rd_mux = nxt_aff_w[QW-1:DW];
         AW'(OFS_NXT_CFG):     rd_mux = nxt_cfg_w;
         AW'(OFS_NXT_CMD):     rd_mux = nxt_cmd_w;
         default:              rd_mux = '0;
      endcase
   end

   if (RD_REG) begin : g_rd_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_data <= '0;
         else        rd_data <= rd_mux;
      end
   end else begin : g_rd_comb
      assign rd_data = rd_mux;
   end
endmodule

// File: rtl/slotc_chk.sv
module slotc_chk
   import slotc_pkg::*;
#(
   parameter int AW = 8,
   parameter int DW = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr_en,
   input logic [AW-1:0]   wr_addr,
   input logic [DW-1:0]   wr_data,
   input logic [7:0]      status,
   input logic [2*DW-1:0] nxt_head,
   input logic            job_done_o,
   input logic            job_failed_o,
   input logic            stop_accept_o,
   input logic            proto_err_o
);
   logic start_wr, now_wr;
   assign start_wr = wr_en && wr_addr == AW'(OFS_NXT_CMD) && wr_data == DW'(1);
   assign now_wr   = wr_en && wr_addr == AW'(OFS_CMD_NOW);

   // R3
   start_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_wr |=> status == ST_ACTIVE);

   // R4
   head_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_wr |=> nxt_head == '0);

   // R5
   close_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_wr |=> ##1 (job_done_o ^ job_failed_o));

   // R5
   no_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(job_done_o && job_failed_o));

   // R8
   proto_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (now_wr && wr_data == DW'(1)) |=> proto_err_o);

   // R1
   ignore_big_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (now_wr && wr_data[DW-1:3] != '0) |=> !stop_accept_o && !proto_err_o);

   // R6
   stop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_accept_o |-> $past(now_wr));
endmodule

bind slot_cmd_ctrl slotc_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .status(status_w), .nxt_head(nxt_head_w),
   .job_done_o(job_done_o), .job_failed_o(job_failed_o),
   .stop_accept_o(stop_accept_o), .proto_err_o(proto_err_o)
);

// File: tb/sim_slot_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_slot_cmd_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [7:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [7:0]  exit_code_i = '0;
   logic job_done_o, job_failed_o, stop_accept_o, stop_hard_o, proto_err_o;

   int n_cmp = 0, n_bad = 0, cyc = 0;
   bit fin = 1'b0, chain_m = 1'b0;
   logic [31:0] nxt_cfg_m = '0;

   typedef struct { int c; bit d, f, s, h, e; string tag; } ev_t;
   ev_t q[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   slot_cmd_ctrl u0 (.*);

   task automatic push(int c, bit d, bit f, bit s, bit h, bit e, string tag);
      ev_t ev;
      if (q.size() > 0 && q[$].c == c) begin
         q[$].d |= d; q[$].f |= f; q[$].s |= s; q[$].h |= h; q[$].e |= e;
         q[$].tag = {q[$].tag, "+", tag};
      end else begin
         ev.c = c; ev.d = d; ev.f = f; ev.s = s; ev.h = h; ev.e = e; ev.tag = tag;
         q.push_back(ev);
      end
   endtask

   // driver: one bus write, expected pulses pushed to the scoreboard
   task automatic wr(logic [7:0] a, logic [31:0] d, string tag);
      int c;
      @(negedge clk);
      c = cyc;
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      if (a == 8'h50) nxt_cfg_m = d;
      if (a == 8'h54 && d == 32'd1) begin
         chain_m = nxt_cfg_m[8];
         if (exit_code_i[7:6] == 2'b01) push(c + 2, 0, 1, 0, 0, 0, tag);
         else                           push(c + 2, 1, 0, 0, 0, 0, tag);
      end
      if (a == 8'h20) begin
         case (d)
            32'd1: push(c + 1, 0, 0, 0, 0, 1, tag);
            32'd2: push(c + 1, 0, 0, 1, 0, 0, tag);
            32'd3: push(c + 1, 0, 0, 1, 1, 0, tag);
            32'd4: if (!chain_m) push(c + 1, 0, 0, 1, 0, 0, tag);
            32'd5: if (!chain_m) push(c + 1, 0, 0, 1, 1, 0, tag);
            32'd6: if (chain_m)  push(c + 1, 0, 0, 1, 0, 0, tag);
            32'd7: if (chain_m)  push(c + 1, 0, 0, 1, 1, 0, tag);
            default: ;
         endcase
      end
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
      @(negedge clk);
      rd_addr = a;
      #0.5;
      n_cmp++;
      if (rd_data !== exp) begin
         n_bad++;
         $display("FAIL %s: read 0x%02h got 0x%08h expected 0x%08h", tag, a, rd_data, exp);
      end
   endtask

   // monitor: pops expected pulse sets and compares every cycle
   always @(negedge clk) begin
      if (rst_n && !fin) begin
         ev_t e;
         e.c = cyc; e.d = 0; e.f = 0; e.s = 0; e.h = 0; e.e = 0; e.tag = "R10 idle";
         if (q.size() > 0 && q[0].c == cyc) e = q.pop_front();
         if (e.d || e.f || e.s || e.h || e.e ||
             job_done_o || job_failed_o || stop_accept_o || stop_hard_o || proto_err_o) begin
            n_cmp++;
            if ({job_done_o, job_failed_o, stop_accept_o, stop_hard_o, proto_err_o}
                !== {e.d, e.f, e.s, e.h, e.e}) begin
               n_bad++;
               $display("FAIL %s: cycle %0d pulses d/f/s/h/e got %b expected %b", e.tag, cyc,
                        {job_done_o, job_failed_o, stop_accept_o, stop_hard_o, proto_err_o},
                        {e.d, e.f, e.s, e.h, e.e});
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!fin) begin
         n_bad++;
         $display("FAIL watchdog: run hung, got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R10 reset state
      rd(8'h1C, 32'h00, "R10 status");
      rd(8'h00, 32'h0,  "R10 head");
      rd(8'h54, 32'h0,  "R10 nxtcmd");
      // staging, chain flag clear
      wr(8'h40, 32'h1111_2220, "R3");
      wr(8'h44, 32'h0000_00AB, "R3");
      wr(8'h48, 32'h0000_000F, "R3");
      wr(8'h4C, 32'h8000_0000, "R3");
      wr(8'h50, 32'h0000_0012, "R3");
      // R2 non-start value stays
      wr(8'h54, 32'd5, "R2");
      rd(8'h54, 32'd5, "R2 stored");
      rd(8'h1C, 32'h00, "R2 no start");
      rd(8'h00, 32'h0, "R2 no transfer");
      // start, normal exit
      exit_code_i = 8'h00;
      wr(8'h54, 32'd1, "R5 done");
      rd(8'h1C, 32'h08, "R3 active");
      rd(8'h1C, 32'h01, "R5 done status");
      rd(8'h00, 32'h1111_2220, "R3 head lo");
      rd(8'h04, 32'h0000_00AB, "R3 head hi");
      rd(8'h08, 32'h1111_2220, "R3 tail lo");
      rd(8'h0C, 32'h0000_00AB, "R3 tail hi");
      rd(8'h10, 32'h0000_000F, "R3 aff lo");
      rd(8'h14, 32'h8000_0000, "R3 aff hi");
      rd(8'h18, 32'h0000_0012, "R3 cfg");
      rd(8'h40, 32'h0, "R4 nxt head lo");
      rd(8'h44, 32'h0, "R4 nxt head hi");
      rd(8'h54, 32'h0, "R4 nxt cmd");
      rd(8'h48, 32'h0000_000F, "R4 aff kept");
      rd(8'h50, 32'h0000_0012, "R4 cfg kept");
      // stops, chain clear
      wr(8'h20, 32'd2, "R6 soft");
      wr(8'h20, 32'd3, "R6 hard");
      wr(8'h20, 32'd4, "R7 soft nc");
      wr(8'h20, 32'd5, "R7 hard nc");
      wr(8'h20, 32'd6, "R7 soft ch blocked");
      wr(8'h20, 32'd7, "R7 hard ch blocked");
      rd(8'h1C, 32'h01, "R6 status kept");
      // illegal start and ignored codes
      wr(8'h20, 32'd1, "R8 proto err");
      wr(8'h20, 32'd0, "R1 nop");
      wr(8'h20, 32'd9, "R1 big");
      wr(8'h20, 32'h100, "R1 big");
      rd(8'h1C, 32'h01, "R8 status kept");
      rd(8'h00, 32'h1111_2220, "R8 no transfer");
      // R9 dropped writes
      wr(8'h00, 32'hDEAD_BEEF, "R9");
      wr(8'h1C, 32'h0000_0055, "R9");
      wr(8'h18, 32'hFFFF_FFFF, "R9");
      wr(8'h7C, 32'h1234_5678, "R9");
      rd(8'h00, 32'h1111_2220, "R9 head");
      rd(8'h1C, 32'h01, "R9 status");
      rd(8'h18, 32'h0000_0012, "R9 cfg");
      rd(8'h7C, 32'h0, "R9 unmapped");
      // chain set, faulting job
      wr(8'h40, 32'h0000_4000, "R3");
      wr(8'h50, 32'h0000_0100, "R7");
      exit_code_i = 8'h45;
      wr(8'h54, 32'd1, "R5 fail");
      rd(8'h1C, 32'h08, "R3 active 2");
      rd(8'h1C, 32'h45, "R5 fault status");
      rd(8'h00, 32'h0000_4000, "R3 head 2");
      rd(8'h04, 32'h0, "R3 head hi 2");
      wr(8'h20, 32'd6, "R7 soft ch");
      wr(8'h20, 32'd7, "R7 hard ch");
      wr(8'h20, 32'd4, "R7 soft nc blocked");
      wr(8'h20, 32'd5, "R7 hard nc blocked");
      // concurrency: close and stop in the same cycle
      exit_code_i = 8'h80;
      wr(8'h54, 32'd1, "R5 done 3");
      wr(8'h20, 32'd2, "R6 concurrent");
      rd(8'h1C, 32'h01, "R5 status 3");
      // start then protocol error in the next cycle
      exit_code_i = 8'h00;
      wr(8'h54, 32'd1, "R5 done 4");
      wr(8'h20, 32'd1, "R8 concurrent");
      rd(8'h1C, 32'h01, "R8 status 4");
      repeat (4) @(negedge clk);
      n_cmp++;
      if (q.size() != 0) begin
         n_bad++;
         $display("FAIL R5: %0d expected events left got %0d expected 0", q.size(), q.size());
      end
      fin = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule